// File: doc/BRIEF.md
# Free-Running Timer with Coherent Byte Read

This block is a 16-bit up-counter that runs freely from the internal bus clock through a fixed divide-by-four prescaler. Its count can be read over a byte-wide, read-only register port. The upper byte sits at address 0x18 and the lower byte at 0x19. Software reads the upper byte first and then the lower byte. Reading the upper byte freezes a private copy of the lower byte, so the two bytes always come from the same instant even though the counter keeps running between the two accesses.

After reset the counter holds 0xFFFC. It stays there until the `clk_ready` input goes high, which marks the end of the clock start-up wait. When the counter wraps from 0xFFFF to 0x0000 it sets a sticky overflow flag. The flag, gated by an enable input, drives an interrupt request.

The read-buffer control is a two-state machine. In LT_LIVE, a low-byte read passes the running low byte straight through. The transition LT_LIVE to LT_HELD is taken on a high-byte read, and it captures the low byte into the buffer. In LT_HELD, low-byte reads return the buffer, and further high-byte reads keep the state and leave the buffer alone. The transition LT_HELD to LT_LIVE is taken on the next low-byte read.

Top module: `frt_timer`

## Requirements
- R1: While `rst_n` is low, the count is set to 0xFFFC, the prescaler phase to zero, the overflow flag to 0 and the read buffer to LT_LIVE. With `clk_ready` low, the count does not change.
- R2: With `clk_ready` high, the count increases by exactly one on every fourth rising clock edge after `clk_ready` rises, and on no other edge.
- R3: In LT_LIVE, a read of address 0x19 returns the current low byte of the count on `rd_data` in the same cycle.
- R4: A read of 0x18 in LT_LIVE returns the current high byte and captures the low byte. Reads of 0x19 then return that captured byte. The first such read ends the hold, and the read after it is live again.
- R5: Reads of 0x18 while in LT_HELD return the live high byte and do not recapture the buffer.
- R6: An access with `acc_we` = 1 at 0x18 or 0x19 returns 0 on `rd_data`. It changes neither the count nor the buffer state or contents.
- R7: An access is a read when `acc_en` = 1 and `acc_we` = 0. `rd_data` is 0 for reads of any address other than 0x18 and 0x19, and it is 0 when no read is made.
- R8: On the count edge that takes the count from 0xFFFF to 0x0000, `ovf_flag` becomes 1.
- R9: `ovf_flag` stays 1 until a clock edge with `ovf_clr` high. It then reads 0 unless a wrap happens on that same edge.
- R10: `ovf_irq` equals `ovf_flag` AND `ovf_ie`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_ready | input | 1 | Start-up wait finished; counting allowed |
| acc_en | input | 1 | Register access strobe |
| acc_we | input | 1 | Access direction: 1 = write (ignored), 0 = read |
| acc_addr | input | 8 | Register address |
| rd_data | output | 8 | Read data for the addressed byte |
| ovf_clr | input | 1 | Clears the overflow flag |
| ovf_ie | input | 1 | Overflow interrupt enable |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
The counter is checked in three phases:
- **Idle after reset:** a lone low-byte read tells a live path apart from a buffered one.
- **Through the 0xFFFF wrap:** a low-byte read on every cycle shows the exact divide-by-four cadence, and whether the flag rises on the right edge.
- **Split read:** a high-byte read, a wait long enough for several count steps, a second high-byte read and then two low-byte reads separate a correct hold from a buffer that is refreshed too often or released too early.

Writes are placed both between reads and in the middle of a held sequence, which shows that writes reach neither the count nor the buffer.

// File: rtl/frt_pkg.sv
package frt_pkg;
    typedef enum logic {
        LT_LIVE = 1'b0,
        LT_HELD = 1'b1
    } latch_state_t;
endpackage

// File: rtl/frt_prescaler.sv
module frt_prescaler #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    generate
        if (DIV <= 1) begin : g_direct
            assign tick_o = run_i;
        end else begin : g_divide
            localparam int PH_W = $clog2(DIV);
            localparam logic [PH_W-1:0] LAST = PH_W'(DIV - 1);
            logic [PH_W-1:0] ph_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ph_q <= '0;
                end else if (run_i) begin
                    ph_q <= (ph_q == LAST) ? '0 : ph_q + 1'b1;
                end
            end

            assign tick_o = run_i && (ph_q == LAST);

            // R2
            tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick_o |=> !tick_o);
        end
    endgenerate
endmodule

// File: rtl/frt_counter.sv
module frt_counter #(
    parameter int              W         = 16,
    parameter logic [W-1:0]    RESET_VAL = 16'hFFFC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_i,
    output logic [W-1:0] cnt_o,
    output logic         wrap_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= RESET_VAL;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign wrap_o = tick_i && (cnt_q == '1);

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R1
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_q));
endmodule

// File: rtl/frt_read_latch.sv
module frt_read_latch
    import frt_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_hi_i,
    input  logic          rd_lo_i,
    input  logic [DW-1:0] lo_live_i,
    output logic [DW-1:0] lo_data_o
);
    latch_state_t  state_q, state_d;
    logic [DW-1:0] buf_q;

    // state register and buffer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LT_LIVE;
            buf_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == LT_LIVE && rd_hi_i) begin
                buf_q <= lo_live_i;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_d   = state_q;
        lo_data_o = lo_live_i;
        unique case (state_q)
            LT_LIVE: begin
                if (rd_hi_i) state_d = LT_HELD;
            end
            LT_HELD: begin
                lo_data_o = buf_q;
                if (rd_lo_i) state_d = LT_LIVE;
            end
            default: state_d = LT_LIVE;
        endcase
    end

    // R4
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LT_LIVE && rd_hi_i) |=>
            (state_q == LT_HELD && buf_q == $past(lo_live_i)));

    // R5
    held_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LT_HELD) |=> $stable(buf_q));
endmodule

// File: rtl/frt_ovf_flag.sv
module frt_ovf_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic ie_i,
    output logic flag_o,
    output logic irq_o
);
    logic flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_i) begin
            flag_q <= 1'b1;
        end else if (clr_i) begin
            flag_q <= 1'b0;
        end
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q && ie_i;

    // R8
    wrap_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q);

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !clr_i) |=> flag_q);
endmodule

// File: rtl/frt_timer.sv
module frt_timer #(
    parameter int                  DATA_W    = 8,
    parameter int                  ADDR_W    = 8,
    parameter int                  PRE_DIV   = 4,
    parameter logic [ADDR_W-1:0]   HI_ADDR   = 8'h18,
    parameter logic [2*DATA_W-1:0] RESET_VAL = 16'hFFFC
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_ready,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              ovf_clr,
    input  logic              ovf_ie,
    output logic              ovf_flag,
    output logic              ovf_irq
);
    localparam int                CNT_W   = 2 * DATA_W;
    localparam logic [ADDR_W-1:0] LO_ADDR = HI_ADDR + 1'b1;

    logic              tick;
    logic              wrap;
    logic [CNT_W-1:0]  cnt;
    logic              rd_hi, rd_lo;
    logic [DATA_W-1:0] lo_data;

    assign rd_hi = acc_en && !acc_we && (acc_addr == HI_ADDR);
    assign rd_lo = acc_en && !acc_we && (acc_addr == LO_ADDR);

    frt_prescaler #(.DIV(PRE_DIV)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (clk_ready),
        .tick_o (tick)
    );

    frt_counter #(.W(CNT_W), .RESET_VAL(RESET_VAL)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .cnt_o  (cnt),
        .wrap_o (wrap)
    );

    frt_read_latch #(.DW(DATA_W)) u_latch (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_hi_i   (rd_hi),
        .rd_lo_i   (rd_lo),
        .lo_live_i (cnt[DATA_W-1:0]),
        .lo_data_o (lo_data)
    );

    frt_ovf_flag u_ovf (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (wrap),
        .clr_i  (ovf_clr),
        .ie_i   (ovf_ie),
        .flag_o (ovf_flag),
        .irq_o  (ovf_irq)
    );

    always_comb begin
        if (rd_hi) begin
            rd_data = cnt[CNT_W-1:DATA_W];
        end else if (rd_lo) begin
            rd_data = lo_data;
        end else begin
            rd_data = '0;
        end
    end
endmodule

// File: tb/frt_timer_bench.sv
module frt_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_ready = 1'b0;
    logic       acc_en = 1'b0;
    logic       acc_we = 1'b0;
    logic [7:0] acc_addr = 8'h00;
    logic       ovf_clr = 1'b0;
    logic       ovf_ie = 1'b0;
    logic [7:0] rd_data;
    logic       ovf_flag;
    logic       ovf_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    frt_timer u_frt_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_ready (clk_ready),
        .acc_en    (acc_en),
        .acc_we    (acc_we),
        .acc_addr  (acc_addr),
        .rd_data   (rd_data),
        .ovf_clr   (ovf_clr),
        .ovf_ie    (ovf_ie),
        .ovf_flag  (ovf_flag),
        .ovf_irq   (ovf_irq)
    );

    // reference model from the requirements
    logic [15:0] m_cnt;
    logic [1:0]  m_ph;
    logic        m_flag;
    logic        b_held = 1'b0;
    logic [7:0]  b_buf = 8'h00;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt  <= 16'hFFFC;
            m_ph   <= 2'd0;
            m_flag <= 1'b0;
        end else begin
            if (clk_ready) begin
                m_ph <= m_ph + 2'd1;
                if (m_ph == 2'd3) m_cnt <= m_cnt + 16'd1;
            end
            if (clk_ready && m_ph == 2'd3 && m_cnt == 16'hFFFF) m_flag <= 1'b1;
            else if (ovf_clr) m_flag <= 1'b0;
        end
    end

    // scoreboard
    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      tag;
    } item_t;
    item_t sbq[$];

    task automatic push(input int kind, input logic [7:0] exp, input string tag);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.tag  = tag;
        sbq.push_back(it);
    endtask

    always begin
        @(negedge clk);
        #2;
        while (sbq.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it = sbq.pop_front();
            case (it.kind)
                0:       act = rd_data;
                1:       act = {7'd0, ovf_flag};
                default: act = {7'd0, ovf_irq};
            endcase
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
            end
        end
    end

    // driver
    task automatic step(input logic en, input logic we, input logic [7:0] a, input logic clr);
        @(negedge clk);
        acc_en   = en;
        acc_we   = we;
        acc_addr = a;
        ovf_clr  = clr;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00, 1'b0);
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        logic [7:0] e;
        step(1'b1, 1'b0, a, 1'b0);
        if (a == 8'h18) begin
            e = m_cnt[15:8];
            if (!b_held) begin
                b_held = 1'b1;
                b_buf  = m_cnt[7:0];
            end
        end else if (a == 8'h19) begin
            e = b_held ? b_buf : m_cnt[7:0];
            b_held = 1'b0;
        end else begin
            e = 8'h00;
        end
        push(0, e, tag);
    endtask

    task automatic wr(input logic [7:0] a, input string tag);
        step(1'b1, 1'b1, a, 1'b0);
        push(0, 8'h00, tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(4);
        // R1: reset value held while start-up wait is pending
        rd(8'h19, "R1 R3 live low byte after reset");
        push(0, 8'hFC, "R1 reset low byte 0xFC");
        rd(8'h18, "R1 reset high byte 0xFF");
        push(0, 8'hFF, "R1 reset high byte literal");
        rd(8'h19, "R4 buffered low after high read");
        push(1, 8'h00, "R1 flag clear after reset");
        ovf_ie = 1'b1;
        push(2, 8'h00, "R10 irq low with flag clear");
        rd(8'h17, "R7 unmapped address reads zero");
        idle(1);
        push(0, 8'h00, "R7 no read gives zero");
        clk_ready = 1'b1;
        // R2 and R8: step through the wrap one cycle at a time
        for (int i = 0; i < 24; i++) begin
            rd(8'h19, "R2 live low byte cadence");
            push(1, {7'd0, m_flag}, "R8 flag versus wrap edge");
        end
        push(1, 8'h01, "R8 flag set after wrap");
        rd(8'h18, "R8 high byte after wrap");
        push(0, 8'h00, "R8 high byte zero after wrap");
        rd(8'h19, "R4 release after wrap read");
        // R10 gating
        idle(1);
        ovf_ie = 1'b0;
        push(2, 8'h00, "R10 irq masked");
        idle(1);
        ovf_ie = 1'b1;
        push(2, 8'h01, "R10 irq enabled");
        // R9 sticky and clear
        idle(5);
        push(1, 8'h01, "R9 flag holds");
        step(1'b0, 1'b0, 8'h00, 1'b1);
        idle(1);
        push(1, 8'h00, "R9 flag cleared");
        push(2, 8'h00, "R10 irq drops with flag");
        // R4 and R5 coherent read
        rd(8'h18, "R4 high read captures");
        idle(9);
        rd(8'h18, "R5 repeated high read live");
        idle(5);
        rd(8'h19, "R5 R4 low returns first capture");
        rd(8'h19, "R4 low live after release");
        // R6 writes ignored
        wr(8'h18, "R6 write high reads zero");
        wr(8'h19, "R6 write low reads zero");
        rd(8'h19, "R6 count unaffected by writes");
        rd(8'h18, "R6 high after writes");
        idle(6);
        wr(8'h19, "R6 write during hold");
        wr(8'h18, "R6 write high during hold");
        rd(8'h19, "R6 hold survives writes");
        rd(8'h1A, "R7 address above low reads zero");
        idle(3);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule